// File: doc/BRIEF.md
# PDM-to-PCM Decimation Filter Chain

This block turns one single-bit pulse-density stream from a digital microphone into signed fixed-point audio samples. It has three stages in series. A four-stage cascaded integrator-comb decimator lowers the rate by 16. A boxcar running-average stage then estimates the DC offset and subtracts it from each sample. A time-multiplexed 16-tap low-pass FIR, which uses one multiply-accumulate per clock, lowers the rate by a further 4. Between the stages every sample is a signed 32-bit value with 16 fractional bits (Q16.16).

The upstream logic presents a PDM bit together with a one-cycle strobe, at most once per clock. The block produces one Q16.16 sample with a one-cycle valid pulse for every 64 accepted bits. It has no ready signal and never stalls. It keeps filtering across any reconfiguration that takes place downstream, with no flush and no restart. The FIR tap count equals the decimation factor of the first stage. As a result, one serial dot product always finishes before the next first-stage sample can arrive.

Top module: `pdm_pcm_chain`

## Requirements
- R1: An input bit of 1 enters the first stage as +1 and a bit of 0 enters as -1. The first stage decimates by 16, and its gain of 2^16 is rescaled so that a full-scale input appears as 1.0 (65536) in Q16.16.
- R2: The first-stage output after the 16k-th accepted bit equals the fourfold cascade of 16-sample moving sums of the mapped input, evaluated at that bit. All history before reset counts as zero.
- R3: Each DC-stage output equals its input sample minus floor(S / 256). S is the sum of the most recent 256 first-stage samples, including the current one, with history before reset counted as zero.
- R4: After every 4th DC-stage sample, the FIR output is floor(sum over k=0..15 of c[k]·d[n−k] / 2^15), saturated to signed 32 bits. Here d[n] is the newest sample and the coefficients c = {-120, -260, -180, 420, 1650, 3474, 5300, 6100}, mirrored for k=8..15, sum to 32768.
- R5: `pcm_valid` is a single-cycle pulse. It fires exactly once per 64 accepted input bits, within 32 clock cycles of the 64th bit.
- R6: An input bit is accepted on any cycle in which `pdm_valid` is high, including back-to-back cycles. The results do not depend on gaps between strobes.
- R7: Reset clears every integrator, comb delay, averaging history and FIR delay line. While reset is held, `pcm_valid` and `pcm_data` are 0, and the output sequence after reset depends only on the bits fed after it.
- R8: A constant input bit stream yields an output of exactly 0 once the averaging window has filled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pdm_valid | input | 1 | Strobe: `pdm_bit` carries a new sample |
| pdm_bit | input | 1 | PDM microphone bit |
| pcm_valid | output | 1 | One-cycle pulse marking a new PCM sample |
| pcm_data | output | 32 | Signed Q16.16 PCM sample |

## Verification
Several properties are checked on every cycle:
- Each stage emits only in the cycle after an accepted input.
- The first-stage output never leaves ±1.0 and the DC stage stays inside ±2.0.
- A new FIR dot product never starts while the previous one still has taps left.
- The output pulse is one cycle wide and falls in the right window of accepted bits.

Bit-exact arithmetic needs the bench's scenarios. These are the 4th-order moving-sum response, the floor of the window mean, the coefficient weighting and rounding, and the restart after a mid-stream reset. The bench compares a sigma-delta sine, an alternating pattern and a constant stream against its own model of the chain.

// File: rtl/pdm_pcm_pkg.sv
package pdm_pcm_pkg;

  localparam int QW = 32;  // inter-stage word
  localparam int QF = 16;  // fractional bits

  typedef logic signed [QW-1:0] q16_t;

  // Clamp a wide signed value into the inter-stage word.
  function automatic q16_t sat_q16(input logic signed [63:0] v);
    if (v > 64'sd2147483647)       return q16_t'(32'sh7fffffff);
    else if (v < -64'sd2147483648) return q16_t'(32'sh80000000);
    else                           return q16_t'(v[31:0]);
  endfunction

  // Map a PDM bit to a two-bit signed level: 1 -> +1, 0 -> -1.
  function automatic logic signed [1:0] pdm_level(input logic b);
    return b ? 2'sb01 : 2'sb11;
  endfunction

  // Symmetric 16-tap low-pass coefficients, Q1.15, unity DC gain.
  function automatic logic signed [15:0] lp_coef(input int k);
    int m;
    m = (k < 8) ? k : 15 - k;
    case (m)
      0:       return -16'sd120;
      1:       return -16'sd260;
      2:       return -16'sd180;
      3:       return  16'sd420;
      4:       return  16'sd1650;
      5:       return  16'sd3474;
      6:       return  16'sd5300;
      default: return  16'sd6100;
    endcase
  endfunction

endpackage

// File: rtl/pdm_cic_decim.sv
module pdm_cic_decim
  import pdm_pcm_pkg::*;
#(
  parameter int RATE   = 16,
  parameter int STAGES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_bit,
  output logic out_valid,
  output q16_t out_data
);

  localparam int LOG2R  = $clog2(RATE);
  localparam int GROWTH = STAGES * LOG2R;
  localparam int AW     = GROWTH + 2;

  logic signed [AW-1:0] integ_q [STAGES];
  logic signed [AW-1:0] integ_d [STAGES];
  logic signed [AW-1:0] comb_dly [STAGES];
  logic signed [AW-1:0] comb_v [STAGES+1];
  logic [LOG2R-1:0]     phase;
  logic                 dec_tick;
  logic signed [1:0]    lvl;
  q16_t                 cic_scaled;

  assign lvl      = pdm_level(in_bit);
  assign dec_tick = in_valid && (phase == LOG2R'(RATE - 1));

  always_comb begin
    integ_d[0] = integ_q[0] + AW'(lvl);
    for (int s = 1; s < STAGES; s++) integ_d[s] = integ_q[s] + integ_d[s-1];
    comb_v[0] = integ_d[STAGES-1];
    for (int s = 0; s < STAGES; s++) comb_v[s+1] = comb_v[s] - comb_dly[s];
  end

  generate
    if (GROWTH >= QF) begin : g_down
      assign cic_scaled = q16_t'(comb_v[STAGES] >>> (GROWTH - QF));
    end else begin : g_up
      assign cic_scaled = q16_t'(comb_v[STAGES]) <<< (QF - GROWTH);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) begin
        integ_q[s]  <= '0;
        comb_dly[s] <= '0;
      end
      phase     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (in_valid) begin
        for (int s = 0; s < STAGES; s++) integ_q[s] <= integ_d[s];
        phase <= phase + 1'b1;
      end
      if (dec_tick) begin
        for (int s = 0; s < STAGES; s++) comb_dly[s] <= comb_v[s];
        out_data  <= cic_scaled;
        out_valid <= 1'b1;
      end
    end
  end

  // R1: a decimated sample only follows an accepted input bit
  a_r1_tick_after_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  // R2: a boxcar of +-1 values never exceeds full scale
  a_r2_cic_full_scale: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data <= (32'sd1 <<< QF)) && (out_data >= -(32'sd1 <<< QF)));

endmodule

// File: rtl/dc_block_avg.sv
module dc_block_avg
  import pdm_pcm_pkg::*;
#(
  parameter int WIN_LOG2 = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  q16_t in_data,
  output logic out_valid,
  output q16_t out_data
);

  localparam int DEPTH = 1 << WIN_LOG2;
  localparam int SW    = QW + WIN_LOG2;

  q16_t                hist [DEPTH];
  logic [WIN_LOG2-1:0] wptr;
  logic signed [SW-1:0] win_sum;
  logic signed [SW-1:0] sum_next;
  logic signed [SW-1:0] dc_est;
  logic signed [SW:0]   diff;

  always_comb begin
    sum_next = win_sum + SW'(in_data) - SW'(hist[wptr]);
    dc_est   = sum_next >>> WIN_LOG2;
    diff     = (SW+1)'(in_data) - (SW+1)'(dc_est);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
      wptr      <= '0;
      win_sum   <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (in_valid) begin
        hist[wptr] <= in_data;
        wptr       <= wptr + 1'b1;
        win_sum    <= sum_next;
        out_data   <= sat_q16(64'(diff));
        out_valid  <= 1'b1;
      end
    end
  end

  // R3: exactly one corrected sample per incoming sample
  a_r3_one_out_per_in: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  // R3: sample minus mean of full-scale samples stays within +-2.0
  a_r3_dc_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data <= (32'sd2 <<< QF)) && (out_data >= -(32'sd2 <<< QF)));

endmodule

// File: rtl/fir_serial_decim.sv
module fir_serial_decim
  import pdm_pcm_pkg::*;
#(
  parameter int TAPS  = 16,
  parameter int DECIM = 4,
  parameter int CW    = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  q16_t in_data,
  output logic out_valid,
  output q16_t out_data
);

  localparam int KW   = $clog2(TAPS);
  localparam int PW   = $clog2(DECIM);
  localparam int PRW  = QW + CW;
  localparam int ACCW = PRW + KW;

  q16_t                  line [TAPS];
  logic [PW-1:0]         phase;
  logic [KW-1:0]         tap;
  logic                  busy;
  logic signed [ACCW-1:0] acc;
  logic signed [ACCW-1:0] acc_next;
  logic signed [PRW-1:0]  prod;
  logic signed [ACCW-1:0] scaled;
  logic                  mac_start;
  logic                  mac_last;

  assign mac_start = in_valid && (phase == PW'(DECIM - 1));
  assign mac_last  = busy && (tap == KW'(TAPS - 1));

  always_comb begin
    prod     = line[tap] * lp_coef(int'(tap));
    acc_next = acc + ACCW'(prod);
    scaled   = acc_next >>> (CW - 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TAPS; i++) line[i] <= '0;
      phase     <= '0;
      tap       <= '0;
      busy      <= 1'b0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (busy) begin
        if (mac_last) begin
          busy      <= 1'b0;
          out_data  <= sat_q16(64'(scaled));
          out_valid <= 1'b1;
        end else begin
          tap <= tap + 1'b1;
          acc <= acc_next;
        end
      end
      if (in_valid) begin
        for (int i = TAPS - 1; i > 0; i--) line[i] <= line[i-1];
        line[0] <= in_data;
        phase   <= mac_start ? '0 : phase + 1'b1;
        if (mac_start) begin
          busy <= 1'b1;
          tap  <= '0;
          acc  <= '0;
        end
      end
    end
  end

  // R4: the serial dot product has finished (or is on its last tap) when the next one starts
  a_r4_mac_fits_window: assert property (@(posedge clk) disable iff (!rst_n)
    mac_start |-> (!busy || mac_last));

  // R5: output strobe is one cycle wide
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

endmodule

// File: rtl/pdm_pcm_chain.sv
module pdm_pcm_chain
  import pdm_pcm_pkg::*;
#(
  parameter int CIC_RATE   = 16,
  parameter int CIC_STAGES = 4,
  parameter int AVG_LOG2   = 8,
  parameter int FIR_TAPS   = 16,
  parameter int FIR_DECIM  = 4,
  parameter int COEF_W     = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pdm_valid,
  input  logic        pdm_bit,
  output logic        pcm_valid,
  output logic [31:0] pcm_data
);

  localparam int SPAN = CIC_RATE * FIR_DECIM;

  logic cic_valid;
  q16_t cic_data;
  logic dc_valid;
  q16_t dc_data;
  q16_t fir_data;

  pdm_cic_decim #(.RATE(CIC_RATE), .STAGES(CIC_STAGES)) u_cic (
    .clk(clk), .rst_n(rst_n),
    .in_valid(pdm_valid), .in_bit(pdm_bit),
    .out_valid(cic_valid), .out_data(cic_data)
  );

  dc_block_avg #(.WIN_LOG2(AVG_LOG2)) u_dc (
    .clk(clk), .rst_n(rst_n),
    .in_valid(cic_valid), .in_data(cic_data),
    .out_valid(dc_valid), .out_data(dc_data)
  );

  fir_serial_decim #(.TAPS(FIR_TAPS), .DECIM(FIR_DECIM), .CW(COEF_W)) u_fir (
    .clk(clk), .rst_n(rst_n),
    .in_valid(dc_valid), .in_data(dc_data),
    .out_valid(pcm_valid), .out_data(fir_data)
  );

  assign pcm_data = fir_data;

  // Rate bookkeeping for the output-window assertion.
  logic [31:0] smp_cnt;
  logic [31:0] pcm_cnt;
  logic [31:0] win_lo;

  assign win_lo = (pcm_cnt + 32'd1) * 32'(SPAN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_cnt <= '0;
      pcm_cnt <= '0;
    end else begin
      if (pdm_valid) smp_cnt <= smp_cnt + 32'd1;
      if (pcm_valid) pcm_cnt <= pcm_cnt + 32'd1;
    end
  end

  // R5: the n-th output lands after the 64n-th bit and within 32 cycles of it
  a_r5_output_window: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_valid |-> (smp_cnt >= win_lo) && (smp_cnt < win_lo + 32'd32));

endmodule

// File: tb/pdm_pcm_chain_bench.sv
module pdm_pcm_chain_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pdm_valid = 1'b0;
  logic        pdm_bit = 1'b0;
  logic        pcm_valid;
  logic [31:0] pcm_data;

  always #4 clk = ~clk;

  pdm_pcm_chain u_pdm_pcm_chain (
    .clk(clk), .rst_n(rst_n),
    .pdm_valid(pdm_valid), .pdm_bit(pdm_bit),
    .pcm_valid(pcm_valid), .pcm_data(pcm_data)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int coef_tb [16] = '{-120, -260, -180, 420, 1650, 3474, 5300, 6100,
                       6100, 5300, 3474, 1650, 420, -180, -260, -120};

  int      mhist [4][16];
  longint  ybuf [256];
  longint  dbuf [16];
  int      m_in;
  int      m_cic;
  longint  exp_q [$];
  int      outs_seen;
  int      ins_sent;
  longint  last_out;
  string   tag;
  real     sd_acc;
  int      sd_n;

  function void check(bit ok, string req, longint act, longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endfunction

  function void model_reset();
    for (int s = 0; s < 4; s++) for (int j = 0; j < 16; j++) mhist[s][j] = 0;
    for (int j = 0; j < 256; j++) ybuf[j] = 0;
    for (int j = 0; j < 16; j++) dbuf[j] = 0;
    m_in = 0;
    m_cic = 0;
    exp_q.delete();
  endfunction

  // Model: four cascaded 16-sample moving sums, boxcar mean, FIR dot product.
  function void model_push(bit b);
    int v;
    int s;
    longint sum;
    longint avg;
    longint acc;
    v = b ? 1 : -1;
    for (int st = 0; st < 4; st++) begin
      for (int j = 15; j > 0; j--) mhist[st][j] = mhist[st][j-1];
      mhist[st][0] = v;
      s = 0;
      for (int j = 0; j < 16; j++) s += mhist[st][j];
      v = s;
    end
    m_in++;
    if (m_in % 16 == 0) begin
      for (int j = 255; j > 0; j--) ybuf[j] = ybuf[j-1];
      ybuf[0] = v;
      sum = 0;
      for (int j = 0; j < 256; j++) sum += ybuf[j];
      avg = sum >>> 8;
      for (int j = 15; j > 0; j--) dbuf[j] = dbuf[j-1];
      dbuf[0] = longint'(v) - avg;
      m_cic++;
      if (m_cic % 4 == 0) begin
        acc = 0;
        for (int k = 0; k < 16; k++) acc += longint'(coef_tb[k]) * dbuf[k];
        exp_q.push_back(acc >>> 15);
      end
    end
  endfunction

  function bit sd_next();
    real target;
    real e;
    bit b;
    target = 0.5 * $sin(2.0 * 3.14159265 * real'(sd_n) / 1500.0) + 0.2;
    sd_n++;
    e = sd_acc + target;
    b = (e >= 0.0);
    sd_acc = e - (b ? 1.0 : -1.0);
    return b;
  endfunction

  task automatic send(bit b, int gap);
    @(negedge clk);
    pdm_valid = 1'b1;
    pdm_bit   = b;
    model_push(b);
    ins_sent++;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      pdm_valid = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    pdm_valid = 1'b0;
    rst_n = 1'b0;
    model_reset();
    outs_seen = 0;
    ins_sent  = 0;
    repeat (3) @(negedge clk);
    check(pcm_valid == 1'b0, "R7 valid low in reset", longint'(pcm_valid), 0);
    check(pcm_data == 32'd0, "R7 data zero in reset", longint'(signed'(pcm_data)), 0);
    rst_n = 1'b1;
  endtask

  task automatic drain(string req);
    @(negedge clk);
    pdm_valid = 1'b0;
    repeat (40) @(negedge clk);
    check(exp_q.size() == 0, {req, " R5 outputs pending"}, exp_q.size(), 0);
    check(outs_seen == ins_sent / 64, {req, " R5 output count"}, outs_seen, ins_sent / 64);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && pcm_valid) begin
      outs_seen++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected output", longint'(signed'(pcm_data)), 0);
      end else begin
        longint e;
        e = exp_q.pop_front();
        last_out = longint'(signed'(pcm_data));
        check(last_out == e, {tag, " R2 R3 R4 sample"}, last_out, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog R5 actual=%0d expected=%0d", outs_seen, ins_sent / 64);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    outs_seen = 0;
    ins_sent  = 0;
    last_out  = 0;
    sd_acc    = 0.0;
    sd_n      = 0;
    tag       = "R1";
    do_reset();

    // Alternating bits with one idle cycle between strobes
    tag = "R1 alternating";
    for (int i = 0; i < 1280; i++) send(i[0], 1);
    drain("R1");

    // Sigma-delta sine, back-to-back strobes
    tag = "R6 sine";
    for (int i = 0; i < 8192; i++) send(sd_next(), 0);
    drain("R6");

    // Reset in mid-stream, then replay the sine from its start
    tag = "R7 pre-reset";
    for (int i = 0; i < 1037; i++) send(sd_next(), 2);
    do_reset();
    sd_acc = 0.0;
    sd_n   = 0;
    tag = "R7 after reset";
    for (int i = 0; i < 2048; i++) send(sd_next(), 0);
    drain("R7");

    // Constant ones: DC is removed completely once the window fills
    do_reset();
    tag = "R8 constant";
    for (int i = 0; i < 6016; i++) send(1'b1, 0);
    drain("R8");
    check(last_out == 0, "R8 settled output", last_out, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule